// File: doc/BRIEF.md
# Stream Width Converter

This block links a narrow valid/ready stream to a wide one on a single clock. The wide side is an exact whole multiple of the narrow side. The build-time parameter `UPSIZE` sets the direction of the link:

- **Upsizing (`UPSIZE=1`).** The block gathers `RATIO` narrow beats into one wide beat.
- **Downsizing (`UPSIZE=0`).** The block splits each wide beat into `RATIO` narrow beats.

Both sides use the usual handshake. A beat moves only in a cycle where valid and ready are both high. A source must keep its data and last flag unchanged while its valid is high and ready is low. The block obeys the same rule on its own output.

Lane order is little-endian. The first narrow beat maps to the least significant lane of the wide beat, and the lanes of a wide beat leave in the same order.

When upsizing, a narrow beat with the last flag set closes the wide beat early. The output carries the last flag, and the unfilled upper lanes read as zero. When downsizing, the last flag of a wide beat appears only on its final narrow beat.

Timing is fixed by the ratio, as follows. All figures assume the consumer holds ready high.

- **Upsizing latency.** From the first input valid to output valid takes `RATIO` cycles.
- **Upsizing input ready.** Input ready never drops.
- **Downsizing latency.** Output valid follows the accepted wide beat by one cycle.
- **Downsizing input ready.** Input ready then stays low for `RATIO-1` cycles.

Top module: `stream_width_conv`

## Requirements
- R1: When upsizing, the k-th narrow beat of a group (counting from 0) lands in bits [k*NARROW_W +: NARROW_W] of the wide beat.
- R2: When upsizing with output ready held high, output valid first rises exactly `RATIO` cycles after the cycle in which the first input beat of a group is valid.
- R3: When upsizing with output ready high, input ready is high in every cycle, so narrow beats are accepted back to back.
- R4: When upsizing, accepting a narrow beat with last set emits the partial wide beat in the next cycle with output last set and all unfilled upper lanes zero. The next group then starts again at lane 0.
- R5: When downsizing, a wide beat leaves as `RATIO` narrow beats, lane 0 (least significant) first.
- R6: When downsizing, output valid is high in the cycle after a wide beat is accepted, carrying lane 0.
- R7: When downsizing with output ready high, input ready is low for exactly `RATIO-1` cycles after each accepted wide beat. It is high again in the cycle the final lane leaves, so the next wide beat can be taken in that cycle.
- R8: When downsizing, output last is high only on the final narrow beat of a wide beat that arrived with last set.
- R9: While output valid is high and output ready is low, output valid stays high and output data and last do not change. When upsizing, input ready is low in that state once a full wide beat is waiting.
- R10: During and right after reset, output valid is low and input ready is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| s_tdata | input | NARROW_W if UPSIZE else NARROW_W*RATIO | Input stream data |
| s_tvalid | input | 1 | Input beat valid |
| s_tready | output | 1 | Block can take the input beat |
| s_tlast | input | 1 | Input beat ends a packet |
| m_tdata | output | NARROW_W*RATIO if UPSIZE else NARROW_W | Output stream data |
| m_tvalid | output | 1 | Output beat valid |
| m_tready | input | 1 | Consumer takes the output beat |
| m_tlast | output | 1 | Output beat ends a packet |

## Verification
Two events can fall in the same cycle, and the bench provokes both with output ready held high.

- **Downsizing.** The final lane of one wide beat leaves in the same cycle the next wide beat is accepted. The bench keeps a second wide beat valid from the cycle after the first is taken. It then expects exactly three low-ready cycles, a high ready on the final-lane cycle, and the second beat's lane 0 in the very next cycle with no gap.
- **Upsizing.** A completed wide beat drains in the same cycle the first narrow beat of the next group is packed. The bench streams eight narrow beats with no pause and checks that input ready never drops and that the second wide word follows exactly four cycles after the first.

A stall case holds output ready low while a new beat waits, to confirm that neither word is disturbed.

// File: rtl/swc_pkg.sv
package swc_pkg;

  // Width of a lane index; at least one bit so ports never collapse.
  function automatic int lane_bits(input int ratio);
    return (ratio > 1) ? $clog2(ratio) : 1;
  endfunction

  // Width of the input stream for a given direction.
  function automatic int in_width(input int narrow_w, input int ratio, input bit upsize);
    return upsize ? narrow_w : narrow_w * ratio;
  endfunction

  // Width of the output stream for a given direction.
  function automatic int out_width(input int narrow_w, input int ratio, input bit upsize);
    return upsize ? narrow_w * ratio : narrow_w;
  endfunction

endpackage

// File: rtl/swc_lane_sel.sv
module swc_lane_sel
  import swc_pkg::*;
#(
  parameter int NARROW_W = 8,
  parameter int RATIO    = 4,
  localparam int WIDE_W  = NARROW_W * RATIO,
  localparam int LB      = lane_bits(RATIO)
) (
  input  logic [WIDE_W-1:0]   wide_i,
  input  logic [LB-1:0]       idx_i,
  output logic [NARROW_W-1:0] lane_o
);

  logic [NARROW_W-1:0] lanes [RATIO];

  for (genvar g = 0; g < RATIO; g++) begin : g_split
    assign lanes[g] = wide_i[g*NARROW_W +: NARROW_W];
  end

  always_comb begin
    lane_o = lanes[0];
    for (int k = 1; k < RATIO; k++) begin
      if (idx_i == LB'(k)) lane_o = lanes[k];
    end
  end

endmodule

// File: rtl/swc_pack.sv
module swc_pack
  import swc_pkg::*;
#(
  parameter int NARROW_W = 8,
  parameter int RATIO    = 4,
  localparam int WIDE_W  = NARROW_W * RATIO,
  localparam int LB      = lane_bits(RATIO)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [NARROW_W-1:0] s_tdata,
  input  logic                s_tvalid,
  output logic                s_tready,
  input  logic                s_tlast,
  output logic [WIDE_W-1:0]   m_tdata,
  output logic                m_tvalid,
  input  logic                m_tready,
  output logic                m_tlast
);

  logic [WIDE_W-1:0] acc_q;
  logic [WIDE_W-1:0] merged;
  logic [LB-1:0]     idx_q;
  logic [WIDE_W-1:0] out_d_q;
  logic              out_v_q;
  logic              out_l_q;
  logic              accept;
  logic              close;

  // Room exists unless a finished word waits and is not draining.
  assign s_tready = !out_v_q || m_tready;
  assign accept   = s_tvalid && s_tready;
  assign close    = accept && (s_tlast || idx_q == LB'(RATIO - 1));

  // Drop the incoming beat into its lane; other lanes keep the gathered
  // data, and lanes above the index are still zero from the last clear.
  for (genvar g = 0; g < RATIO; g++) begin : g_lane
    assign merged[g*NARROW_W +: NARROW_W] =
      (idx_q == LB'(g)) ? s_tdata : acc_q[g*NARROW_W +: NARROW_W];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      acc_q   <= '0;
      idx_q   <= '0;
      out_d_q <= '0;
      out_v_q <= 1'b0;
      out_l_q <= 1'b0;
    end else begin
      if (accept) begin
        if (close) begin
          acc_q <= '0;
          idx_q <= '0;
        end else begin
          acc_q <= merged;
          idx_q <= idx_q + LB'(1);
        end
      end
      if (close) begin
        out_d_q <= merged;
        out_l_q <= s_tlast;
        out_v_q <= 1'b1;
      end else if (m_tready) begin
        out_v_q <= 1'b0;
      end
    end
  end

  assign m_tdata  = out_d_q;
  assign m_tvalid = out_v_q;
  assign m_tlast  = out_l_q;

  // A full group yields an output word on the next cycle.
  p_full_group_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && idx_q == LB'(RATIO - 1)) |=> m_tvalid);

  // A last beat in lane 0 closes with every upper lane zero.
  p_early_close_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && s_tlast && idx_q == '0) |=>
      (m_tvalid && m_tlast && m_tdata[WIDE_W-1:NARROW_W] == '0));

  // The waiting word holds still under back-pressure.
  p_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (m_tvalid && !m_tready) |=>
      (m_tvalid && $stable(m_tdata) && $stable(m_tlast)));

  // The first lane of the output word is the beat that opened the group.
  p_lane0_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && s_tlast && idx_q == '0) |=>
      (m_tdata[NARROW_W-1:0] == $past(s_tdata)));

endmodule

// File: rtl/swc_unpack.sv
module swc_unpack
  import swc_pkg::*;
#(
  parameter int NARROW_W = 8,
  parameter int RATIO    = 4,
  localparam int WIDE_W  = NARROW_W * RATIO,
  localparam int LB      = lane_bits(RATIO)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [WIDE_W-1:0]   s_tdata,
  input  logic                s_tvalid,
  output logic                s_tready,
  input  logic                s_tlast,
  output logic [NARROW_W-1:0] m_tdata,
  output logic                m_tvalid,
  input  logic                m_tready,
  output logic                m_tlast
);

  logic [WIDE_W-1:0] hold_q;
  logic              hold_last_q;
  logic              busy_q;
  logic [LB-1:0]     idx_q;
  logic              final_lane;
  logic              accept;

  assign final_lane = (idx_q == LB'(RATIO - 1));
  // Take a new word when empty, or in the cycle the final lane leaves.
  assign s_tready   = !busy_q || (final_lane && m_tready);
  assign accept     = s_tvalid && s_tready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hold_q      <= '0;
      hold_last_q <= 1'b0;
      busy_q      <= 1'b0;
      idx_q       <= '0;
    end else if (accept) begin
      hold_q      <= s_tdata;
      hold_last_q <= s_tlast;
      busy_q      <= 1'b1;
      idx_q       <= '0;
    end else if (busy_q && m_tready) begin
      if (final_lane) begin
        busy_q <= 1'b0;
        idx_q  <= '0;
      end else begin
        idx_q  <= idx_q + LB'(1);
      end
    end
  end

  swc_lane_sel #(
    .NARROW_W (NARROW_W),
    .RATIO    (RATIO)
  ) sel_i (
    .wide_i (hold_q),
    .idx_i  (idx_q),
    .lane_o (m_tdata)
  );

  assign m_tvalid = busy_q;
  assign m_tlast  = busy_q && hold_last_q && final_lane;

  // After a wide beat is taken, the input closes for at least one cycle.
  p_gap_r7: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> !s_tready);

  // Lane 0 of the accepted word is on the output one cycle later.
  p_first_lane_r6: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> (m_tvalid && m_tdata == $past(s_tdata[NARROW_W-1:0])));

  // The narrow beat holds still under back-pressure.
  p_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (m_tvalid && !m_tready) |=>
      (m_tvalid && $stable(m_tdata) && $stable(m_tlast)));

  // A word without last never raises the output last flag on its first lane.
  p_no_stray_last_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && !s_tlast) |=> !m_tlast);

endmodule

// File: rtl/stream_width_conv.sv
module stream_width_conv
  import swc_pkg::*;
#(
  parameter int NARROW_W = 8,
  parameter int RATIO    = 4,
  parameter bit UPSIZE   = 1'b1
) (
  input  logic                                          clk,
  input  logic                                          rst_n,
  input  logic [in_width(NARROW_W, RATIO, UPSIZE)-1:0]  s_tdata,
  input  logic                                          s_tvalid,
  output logic                                          s_tready,
  input  logic                                          s_tlast,
  output logic [out_width(NARROW_W, RATIO, UPSIZE)-1:0] m_tdata,
  output logic                                          m_tvalid,
  input  logic                                          m_tready,
  output logic                                          m_tlast
);

  initial begin
    if (RATIO < 2) $error("stream_width_conv: RATIO must be at least 2");
  end

  if (UPSIZE) begin : g_up
    swc_pack #(
      .NARROW_W (NARROW_W),
      .RATIO    (RATIO)
    ) pack_i (
      .clk      (clk),
      .rst_n    (rst_n),
      .s_tdata  (s_tdata),
      .s_tvalid (s_tvalid),
      .s_tready (s_tready),
      .s_tlast  (s_tlast),
      .m_tdata  (m_tdata),
      .m_tvalid (m_tvalid),
      .m_tready (m_tready),
      .m_tlast  (m_tlast)
    );
  end else begin : g_down
    swc_unpack #(
      .NARROW_W (NARROW_W),
      .RATIO    (RATIO)
    ) unpack_i (
      .clk      (clk),
      .rst_n    (rst_n),
      .s_tdata  (s_tdata),
      .s_tvalid (s_tvalid),
      .s_tready (s_tready),
      .s_tlast  (s_tlast),
      .m_tdata  (m_tdata),
      .m_tvalid (m_tvalid),
      .m_tready (m_tready),
      .m_tlast  (m_tlast)
    );
  end

  // No output beat is presented while reset is applied.
  p_reset_idle_r10: assert property (@(posedge clk)
    !rst_n |=> !m_tvalid);

endmodule

// File: tb/stream_width_conv_tb_top.sv
`timescale 1ns/1ps
module stream_width_conv_tb_top;

  logic clk = 1'b0;
  logic rst_n;
  always #10 clk = ~clk;

  // Upsizer: 8 -> 32 bits
  logic [7:0]  u_s_tdata;
  logic        u_s_tvalid, u_s_tready, u_s_tlast;
  logic [31:0] u_m_tdata;
  logic        u_m_tvalid, u_m_tready, u_m_tlast;

  // Downsizer: 32 -> 8 bits
  logic [31:0] d_s_tdata;
  logic        d_s_tvalid, d_s_tready, d_s_tlast;
  logic [7:0]  d_m_tdata;
  logic        d_m_tvalid, d_m_tready, d_m_tlast;

  int n_vec = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  stream_width_conv #(.NARROW_W(8), .RATIO(4), .UPSIZE(1'b1)) dut_i (
    .clk(clk), .rst_n(rst_n),
    .s_tdata(u_s_tdata), .s_tvalid(u_s_tvalid), .s_tready(u_s_tready), .s_tlast(u_s_tlast),
    .m_tdata(u_m_tdata), .m_tvalid(u_m_tvalid), .m_tready(u_m_tready), .m_tlast(u_m_tlast)
  );

  stream_width_conv #(.NARROW_W(8), .RATIO(4), .UPSIZE(1'b0)) dut_dn_i (
    .clk(clk), .rst_n(rst_n),
    .s_tdata(d_s_tdata), .s_tvalid(d_s_tvalid), .s_tready(d_s_tready), .s_tlast(d_s_tlast),
    .m_tdata(d_m_tdata), .m_tvalid(d_m_tvalid), .m_tready(d_m_tready), .m_tlast(d_m_tlast)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // R10: state during and after reset
  task automatic t_reset;
    rst_n = 1'b0;
    u_s_tvalid = 0; u_s_tlast = 0; u_s_tdata = '0; u_m_tready = 0;
    d_s_tvalid = 0; d_s_tlast = 0; d_s_tdata = '0; d_m_tready = 0;
    repeat (3) @(negedge clk);
    #1;
    chk("R10 up valid in reset", u_m_tvalid, 0);
    chk("R10 dn valid in reset", d_m_tvalid, 0);
    rst_n = 1'b1;
    @(negedge clk); #1;
    chk("R10 up valid after reset", u_m_tvalid, 0);
    chk("R10 up ready after reset", u_s_tready, 1);
    chk("R10 dn ready after reset", d_s_tready, 1);
  endtask

  // R1 R2 R3: eight beats back to back, two words out
  task automatic t_up_b2b;
    u_m_tready = 1;
    for (int i = 0; i < 9; i++) begin
      @(negedge clk);
      u_s_tvalid = (i < 8);
      u_s_tdata  = 8'(i + 1);
      u_s_tlast  = 0;
      #1;
      if (i < 8) chk("R3 input ready stays high", u_s_tready, 1);
      chk("R2 output valid timing", u_m_tvalid, 32'((i == 4) || (i == 8)));
      if (i == 4) chk("R1 first packed word", u_m_tdata, 32'h04030201);
      if (i == 8) chk("R1 second packed word", u_m_tdata, 32'h08070605);
      if (i == 4) chk("R4 no last on full word", u_m_tlast, 0);
    end
  endtask

  // R4: last on lane 1 closes early, next group restarts at lane 0
  task automatic t_up_last;
    u_m_tready = 1;
    for (int i = 0; i < 8; i++) begin
      @(negedge clk);
      u_s_tvalid = (i != 2) && (i < 7);
      u_s_tdata  = (i < 2) ? 8'(8'hA1 + i) : 8'(8'hB1 + i - 3);
      u_s_tlast  = (i == 1);
      #1;
      if (i == 1) chk("R4 no early output", u_m_tvalid, 0);
      if (i == 2) begin
        chk("R4 partial word valid", u_m_tvalid, 1);
        chk("R4 upper lanes zero", u_m_tdata, 32'h0000A2A1);
        chk("R4 last flag", u_m_tlast, 1);
      end
      if (i == 3) chk("R4 partial drained", u_m_tvalid, 0);
      if (i == 7) begin
        chk("R4 restart at lane 0", u_m_tdata, 32'hB4B3B2B1);
        chk("R4 last clear", u_m_tlast, 0);
      end
    end
  endtask

  // R9: word waits under back-pressure, pending beat not taken
  task automatic t_up_stall;
    for (int i = 0; i < 12; i++) begin
      @(negedge clk);
      u_m_tready = (i >= 7);
      u_s_tlast  = 0;
      u_s_tvalid = (i < 11);
      if (i < 4)       u_s_tdata = 8'(8'hC1 + i);
      else if (i < 8)  u_s_tdata = 8'hD1;
      else             u_s_tdata = 8'(8'hD2 + i - 8);
      #1;
      if (i >= 4 && i <= 6) begin
        chk("R9 word held valid", u_m_tvalid, 1);
        chk("R9 word held data", u_m_tdata, 32'hC4C3C2C1);
        chk("R9 input blocked", u_s_tready, 0);
      end
      if (i == 7) chk("R9 input opens on drain", u_s_tready, 1);
      if (i == 8) chk("R9 drained", u_m_tvalid, 0);
      if (i == 11) chk("R1 word after stall", u_m_tdata, 32'hD4D3D2D1);
    end
  endtask

  // R5 R6: one wide beat, lanes out in order
  task automatic t_dn_order;
    d_m_tready = 1;
    for (int i = 0; i < 6; i++) begin
      @(negedge clk);
      d_s_tvalid = (i == 0);
      d_s_tdata  = 32'h44332211;
      d_s_tlast  = 0;
      #1;
      if (i == 0) begin
        chk("R6 idle before", d_m_tvalid, 0);
        chk("R7 ready when idle", d_s_tready, 1);
      end
      if (i >= 1 && i <= 4) begin
        chk("R6 valid one cycle after", d_m_tvalid, 1);
        chk("R5 lane order", 32'(d_m_tdata), 32'(8'h11 * i));
        chk("R8 no last", d_m_tlast, 0);
      end
      if (i == 5) chk("R5 done after four lanes", d_m_tvalid, 0);
    end
  endtask

  // R7 R8: second word taken in the final-lane cycle
  task automatic t_dn_b2b;
    d_m_tready = 1;
    for (int i = 0; i < 10; i++) begin
      @(negedge clk);
      d_s_tvalid = (i < 5);
      d_s_tdata  = (i == 0) ? 32'h88776655 : 32'hDDCCBBAA;
      d_s_tlast  = (i != 0);
      #1;
      if (i >= 1 && i <= 3) chk("R7 input closed", d_s_tready, 0);
      if (i == 4) chk("R7 input opens on final lane", d_s_tready, 1);
      if (i >= 1 && i <= 4) chk("R5 first word lanes", 32'(d_m_tdata), 32'(8'h55 + 8'h11 * (i - 1)));
      if (i >= 5 && i <= 8) chk("R7 second word no gap", 32'(d_m_tdata), 32'(8'hAA + 8'h11 * (i - 5)));
      if (i >= 1 && i <= 8) chk("R8 last only on final lane", d_m_tlast, 32'(i == 8));
      if (i == 9) chk("R7 stream ends", d_m_tvalid, 0);
    end
  endtask

  // R9 R8: narrow beat held under back-pressure
  task automatic t_dn_stall;
    for (int i = 0; i < 9; i++) begin
      @(negedge clk);
      d_m_tready = (i >= 4);
      d_s_tvalid = (i == 0);
      d_s_tdata  = 32'h04030201;
      d_s_tlast  = 1;
      #1;
      if (i >= 1 && i <= 3) begin
        chk("R9 lane held valid", d_m_tvalid, 1);
        chk("R9 lane held data", 32'(d_m_tdata), 32'h01);
        chk("R9 input closed in stall", d_s_tready, 0);
      end
      if (i >= 4 && i <= 7) begin
        chk("R5 lanes after stall", 32'(d_m_tdata), 32'(i - 3));
        chk("R8 last at end only", d_m_tlast, 32'(i == 7));
      end
      if (i == 8) chk("R6 idle after word", d_m_tvalid, 0);
    end
  endtask

  initial begin
    t_reset();
    t_up_b2b();
    t_up_last();
    t_up_stall();
    t_dn_order();
    t_dn_b2b();
    t_dn_stall();
    repeat (2) @(negedge clk);
    done = 1'b1;
    $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    #2_000_000;
    if (!done) begin
      n_vec++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

endmodule